// File: doc/BRIEF.md
# Virtual Method Dispatch Unit

This unit turns a stream of method-invocation instructions into calls on hardware functional units or on software routines. Each instruction names a method, the object it acts on and one argument. The unit first finds the object's runtime class in a per-object class table. It then reads a per-class method table, which says whether that class/method pair is served by a hardware unit or by a software routine at a given address.

For a hardware target, the selected unit receives a one-cycle start pulse. Only that unit's clock enable is high, and it stays high until the unit reports done. For a software target, a call address is presented with a valid/ready handshake. Because the lookup goes through the object's class, a subclass can send an existing opcode to a software override while objects of the parent class keep using the hardware unit. Methods that exist only in software are reached the same way.

Both tables are loaded through a write-only configuration port. Only one invocation is in flight at a time.

Top module: `method_dispatch`

## Requirements
- R1: After reset, instr_ready is 1, err_unmapped is 0, and fu_start, fu_clk_en and sw_call_valid are all 0. Every method-table entry starts unmapped.
- R2: An instruction is taken on a cycle where instr_valid and instr_ready are both 1. After that, instr_ready stays 0 until the invocation completes, so only one invocation is outstanding.
- R3: The target is chosen from the class stored for the instruction's object and from the instruction's method. The start pulse or software call appears in the second cycle after the accepting edge.
- R4: For a hardware entry (kind bit 0), fu_start pulses for exactly one cycle, on the bit given by the low 3 bits of the entry's target field. During the call, call_obj and call_arg carry the instruction's object and argument.
- R5: Exactly one fu_clk_en bit, the selected unit's, is high. It rises in the start cycle and stays high through the cycle in which that unit's done is sampled. All enables are 0 at every other time.
- R6: A hardware call ends only on fu_done of the selected unit; done from any other unit is ignored. instr_ready returns to 1 in the cycle after the selected unit's done.
- R7: For a software entry (kind bit 1), sw_call_valid is 1 and sw_call_addr holds the entry's 16-bit target until sw_call_ready is seen. instr_ready returns in the following cycle.
- R8: Two classes can map the same method to different kinds. A subclass entry pointing to software overrides the parent's hardware unit for objects of that subclass only.
- R9: An unmapped class/method pair (valid bit 0) starts no unit and makes no call. It sets err_unmapped, which stays 1 until reset, and instr_ready returns in the same cycle the call would have started.
- R10: A configuration write made while an invocation is in progress (instr_ready is 0) changes neither table.
- R11: A configuration write in the same cycle an instruction is accepted is applied, and that instruction's lookup already sees it.
- R12: Configuration encoding. With cfg_sel=0, object cfg_addr[3:0] gets class cfg_data[2:0]. With cfg_sel=1, entry cfg_addr = {class[2:0], method[2:0]} gets cfg_data[17] = valid, cfg_data[16] = kind, and cfg_data[15:0] = target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit idle and able to take an instruction |
| instr_method | input | 3 | Method opcode |
| instr_obj | input | 4 | Object identifier |
| instr_arg | input | 16 | Argument value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the class table, 1 the method table |
| cfg_addr | input | 6 | Table index |
| cfg_data | input | 18 | Entry value |
| fu_start | output | 8 | One-hot start pulse per functional unit |
| fu_clk_en | output | 8 | Per-unit clock enable |
| fu_done | input | 8 | Per-unit completion |
| sw_call_valid | output | 1 | Software call request |
| sw_call_addr | output | 16 | Software routine address |
| sw_call_ready | input | 1 | Software call taken |
| call_obj | output | 4 | Object of the current call |
| call_arg | output | 16 | Argument of the current call |
| err_unmapped | output | 1 | Sticky unmapped-method flag |

## Verification
Two things can happen on the same edge: a configuration write and the acceptance of an instruction whose lookup depends on the entry being written. Writes that land one and two cycles after acceptance must instead be dropped. The bench drives a class-table write together with the instruction and checks that the call goes to the unit implied by the new class. It also writes conflicting entries during the two lookup cycles of a later call and checks that the call goes to the old unit, both for that call and for the next one. A second collision is a done from a foreign unit arriving while the selected unit is still busy; the bench checks that the enable and ready do not move.

// File: rtl/method_dispatch.sv
module method_dispatch #(
  parameter int OBJ_W  = 4,
  parameter int CLS_W  = 3,
  parameter int MTH_W  = 3,
  parameter int ARG_W  = 16,
  parameter int NFU    = 8,
  parameter int TGT_W  = 16,
  parameter int CFG_AW = (OBJ_W > CLS_W + MTH_W) ? OBJ_W : CLS_W + MTH_W,
  parameter int CFG_DW = TGT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [MTH_W-1:0]  instr_method,
  input  logic [OBJ_W-1:0]  instr_obj,
  input  logic [ARG_W-1:0]  instr_arg,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic [NFU-1:0]    fu_start,
  output logic [NFU-1:0]    fu_clk_en,
  input  logic [NFU-1:0]    fu_done,
  output logic              sw_call_valid,
  output logic [TGT_W-1:0]  sw_call_addr,
  input  logic              sw_call_ready,
  output logic [OBJ_W-1:0]  call_obj,
  output logic [ARG_W-1:0]  call_arg,
  output logic              err_unmapped
);
  localparam int NOBJ   = 1 << OBJ_W;
  localparam int VMT_AW = CLS_W + MTH_W;
  localparam int NVMT   = 1 << VMT_AW;
  localparam int FU_W   = (NFU > 1) ? $clog2(NFU) : 1;

  typedef enum logic [2:0] {S_IDLE, S_OTT, S_VMT, S_HW, S_SW} st_t;

  st_t               state;
  logic [CLS_W-1:0]  cls_tab [NOBJ];
  logic [CFG_DW-1:0] mth_tab [NVMT];
  logic [MTH_W-1:0]  mth_q;
  logic [OBJ_W-1:0]  obj_q;
  logic [ARG_W-1:0]  arg_q;
  logic [CLS_W-1:0]  cls_q;
  logic [TGT_W-1:0]  tgt_q;
  logic              start_q;
  logic              err_q;

  wire               cfg_ok = cfg_we && (state == S_IDLE);
  wire [CFG_DW-1:0]  ent    = mth_tab[{cls_q, mth_q}];
  wire               ent_ok = ent[CFG_DW-1];
  wire               ent_sw = ent[CFG_DW-2];
  wire [FU_W-1:0]    fu_sel = tgt_q[FU_W-1:0];
  wire [NFU-1:0]     fu_hot = {{(NFU-1){1'b0}}, 1'b1} << fu_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NOBJ; i++) cls_tab[i] <= '0;
      for (int j = 0; j < NVMT; j++) mth_tab[j] <= '0;
    end else if (cfg_ok) begin
      if (!cfg_sel) cls_tab[cfg_addr[OBJ_W-1:0]] <= cfg_data[CLS_W-1:0];
      else          mth_tab[cfg_addr[VMT_AW-1:0]] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mth_q   <= '0;
      obj_q   <= '0;
      arg_q   <= '0;
      cls_q   <= '0;
      tgt_q   <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (instr_valid) begin
          mth_q <= instr_method;
          obj_q <= instr_obj;
          arg_q <= instr_arg;
          state <= S_OTT;
        end
        S_OTT: begin
          cls_q <= cls_tab[obj_q];
          state <= S_VMT;
        end
        S_VMT: begin
          tgt_q <= ent[TGT_W-1:0];
          if (!ent_ok) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (ent_sw) begin
            state <= S_SW;
          end else begin
            start_q <= 1'b1;
            state   <= S_HW;
          end
        end
        S_HW: begin
          start_q <= 1'b0;
          if (fu_done[fu_sel]) state <= S_IDLE;
        end
        S_SW: if (sw_call_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign instr_ready   = (state == S_IDLE);
  assign fu_clk_en     = (state == S_HW) ? fu_hot : '0;
  assign fu_start      = start_q ? fu_hot : '0;
  assign sw_call_valid = (state == S_SW);
  assign sw_call_addr  = tgt_q;
  assign call_obj      = obj_q;
  assign call_arg      = arg_q;
  assign err_unmapped  = err_q;
endmodule

// File: rtl/method_dispatch_chk.sv
module method_dispatch_chk #(
  parameter int NFU   = 8,
  parameter int TGT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_ready,
  input logic [NFU-1:0]   fu_start,
  input logic [NFU-1:0]   fu_clk_en,
  input logic [NFU-1:0]   fu_done,
  input logic             sw_call_valid,
  input logic [TGT_W-1:0] sw_call_addr,
  input logic             sw_call_ready,
  input logic             err_unmapped
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_start)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|fu_start) |=> (fu_start == '0)); // R4
  AST_CLKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_clk_en)); // R5
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((fu_start & ~fu_clk_en) == '0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (fu_clk_en == '0 && !sw_call_valid)); // R2
  AST_HW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fu_clk_en) && (fu_done & fu_clk_en) == '0) |=> $stable(fu_clk_en)); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fu_done & fu_clk_en) != '0) |=> instr_ready); // R6
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_call_valid && !sw_call_ready) |=> (sw_call_valid && $stable(sw_call_addr))); // R7
  AST_NO_HW_SW: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_call_valid && (|fu_clk_en))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |=> err_unmapped); // R9
endmodule

bind method_dispatch method_dispatch_chk #(.NFU(NFU), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .fu_start(fu_start),
  .fu_clk_en(fu_clk_en), .fu_done(fu_done), .sw_call_valid(sw_call_valid),
  .sw_call_addr(sw_call_addr), .sw_call_ready(sw_call_ready),
  .err_unmapped(err_unmapped)
);

// File: tb/method_dispatch_tb.sv
module method_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_HW = 2'd0, K_SW = 2'd1, K_ERR = 2'd2;

  typedef struct packed {
    logic [3:0]  obj;
    logic [2:0]  mth;
    logic [15:0] arg;
    logic [1:0]  kind;
    logic [2:0]  idx;
    logic [15:0] addr;
    logic        bw;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd0,  3'd1, 16'h1111, K_HW,  3'd2, 16'h0000, 1'b0}, // R4 parent class on hardware
    '{4'd3,  3'd1, 16'h2222, K_SW,  3'd0, 16'h1200, 1'b0}, // R8 subclass override, same opcode
    '{4'd9,  3'd1, 16'h3333, K_HW,  3'd5, 16'h0000, 1'b0}, // R3 other class, same opcode
    '{4'd9,  3'd2, 16'h4444, K_HW,  3'd7, 16'h0000, 1'b0}, // R3 same object, other method
    '{4'd15, 3'd3, 16'h5555, K_SW,  3'd0, 16'h3400, 1'b0}, // R7 software-only method
    '{4'd0,  3'd2, 16'h6666, K_ERR, 3'd0, 16'h0000, 1'b0}, // R9 unmapped pair
    '{4'd4,  3'd1, 16'h7777, K_ERR, 3'd0, 16'h0000, 1'b0}, // R9 object of empty class 0
    '{4'd3,  3'd1, 16'h8888, K_SW,  3'd0, 16'h1200, 1'b0}, // R8 override again after error
    '{4'd0,  3'd1, 16'h9999, K_HW,  3'd2, 16'h0000, 1'b1}, // R10 writes during this call
    '{4'd0,  3'd1, 16'hAAAA, K_HW,  3'd2, 16'h0000, 1'b0}  // R10 tables unchanged afterwards
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [2:0]  instr_method = '0;
  logic [3:0]  instr_obj = '0;
  logic [15:0] instr_arg = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [17:0] cfg_data = '0;
  logic [7:0]  fu_start, fu_clk_en;
  logic [7:0]  fu_done = '0;
  logic        sw_call_valid;
  logic [15:0] sw_call_addr;
  logic        sw_call_ready = 1'b0;
  logic [3:0]  call_obj;
  logic [15:0] call_arg;
  logic        err_unmapped;

  int checks = 0;
  int fails  = 0;

  logic        co_en = 1'b0;
  logic        co_sel = 1'b0;
  logic [5:0]  co_addr = '0;
  logic [17:0] co_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  method_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_method(instr_method), .instr_obj(instr_obj), .instr_arg(instr_arg),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .fu_start(fu_start), .fu_clk_en(fu_clk_en), .fu_done(fu_done),
    .sw_call_valid(sw_call_valid), .sw_call_addr(sw_call_addr),
    .sw_call_ready(sw_call_ready), .call_obj(call_obj), .call_arg(call_arg),
    .err_unmapped(err_unmapped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [5:0] addr, input logic [17:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input vec_t v);
    logic [7:0] hot;
    hot = 8'd1 << v.idx;
    @(negedge clk);
    chk("R2 ready before issue", instr_ready, 1);
    instr_valid = 1'b1; instr_obj = v.obj; instr_method = v.mth; instr_arg = v.arg;
    if (co_en) begin
      cfg_we = 1'b1; cfg_sel = co_sel; cfg_addr = co_addr; cfg_data = co_data;
    end
    @(negedge clk);
    instr_valid = 1'b0; cfg_we = 1'b0; co_en = 1'b0;
    chk("R2 busy after accept", instr_ready, 0);
    chk("R5 no enable during lookup", fu_clk_en, 0);
    if (v.bw) begin
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 6'd9; cfg_data = {2'b11, 16'hDEAD};
    end
    @(negedge clk);
    if (v.bw) begin
      cfg_sel = 1'b0; cfg_addr = 6'd0; cfg_data = 18'd3;
    end
    chk("R3 nothing before second cycle", {fu_start, 7'd0, sw_call_valid}, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    if (v.kind == K_HW) begin
      chk("R4 start pulse on unit", fu_start, hot);
      chk("R5 clock enable on unit", fu_clk_en, hot);
      chk("R4 call object", call_obj, v.obj);
      chk("R4 call argument", call_arg, v.arg);
      chk("R7 no software call on hw", sw_call_valid, 0);
      fu_done = 8'd1 << ((v.idx + 3'd1) & 3'd7);
      @(negedge clk);
      chk("R4 start is single cycle", fu_start, 0);
      chk("R6 foreign done ignored, enable", fu_clk_en, hot);
      chk("R6 foreign done ignored, ready", instr_ready, 0);
      fu_done = hot;
      @(negedge clk);
      fu_done = '0;
      chk("R6 ready after done", instr_ready, 1);
      chk("R5 enable off after done", fu_clk_en, 0);
    end else if (v.kind == K_SW) begin
      chk("R7 call valid", sw_call_valid, 1);
      chk("R7 call address", sw_call_addr, v.addr);
      chk("R5 no enable for software", fu_clk_en, 0);
      @(negedge clk);
      chk("R7 call held", {sw_call_valid, sw_call_addr}, {1'b1, v.addr});
      sw_call_ready = 1'b1;
      @(negedge clk);
      sw_call_ready = 1'b0;
      chk("R7 ready after handshake", instr_ready, 1);
      chk("R7 call dropped", sw_call_valid, 0);
    end else begin
      chk("R9 no unit started", fu_start, 0);
      chk("R9 no software call", sw_call_valid, 0);
      chk("R9 error flag set", err_unmapped, 1);
      chk("R9 instruction dropped, ready", instr_ready, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", instr_ready, 1);
    chk("R1 reset outputs", {fu_start, fu_clk_en, sw_call_valid, err_unmapped}, 0);

    // R12 class table: object -> class
    cfg_write(1'b0, 6'd0,  18'd1);
    cfg_write(1'b0, 6'd3,  18'd2);
    cfg_write(1'b0, 6'd9,  18'd3);
    cfg_write(1'b0, 6'd15, 18'd2);
    // R12 method table: {class,method} -> {valid,kind,target}
    cfg_write(1'b1, {3'd1, 3'd1}, {2'b10, 16'd2});
    cfg_write(1'b1, {3'd2, 3'd1}, {2'b11, 16'h1200});
    cfg_write(1'b1, {3'd2, 3'd3}, {2'b11, 16'h3400});
    cfg_write(1'b1, {3'd3, 3'd1}, {2'b10, 16'd5});
    cfg_write(1'b1, {3'd3, 3'd2}, {2'b10, 16'd7});

    for (int i = 0; i < 10; i++) begin
      if (i == 5) chk("R9 flag clear before error", err_unmapped, 0);
      run(VECS[i]);
    end

    // R11 class write for object 5 lands in the accepting cycle
    co_en = 1'b1; co_sel = 1'b0; co_addr = 6'd5; co_data = 18'd3;
    run('{4'd5, 3'd1, 16'hBBBB, K_HW, 3'd5, 16'h0000, 1'b0});
    chk("R9 flag still set", err_unmapped, 1);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears error", err_unmapped, 0);
    chk("R1 ready after reset", instr_ready, 1);
    run('{4'd0, 3'd1, 16'hCCCC, K_ERR, 3'd0, 16'h0000, 1'b0}); // R1 tables unmapped after reset

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule